// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from reset to a usable state by driving its command, address, bank, clock-enable and byte-mask pins through the required start-up ordering. After reset it keeps the device quiet for a long settling pause, with clock-enable and the byte masks held high. It then closes every bank, runs a fixed number of auto-refresh cycles and writes the mode register with a value supplied on an input. When the mode-write recovery gap has elapsed it raises `init_done`, which the memory controller that owns normal traffic uses as its start signal.

Every wait is a cycle count. The counts are worked out at elaboration from nanosecond figures and the clock period, rounded up to whole cycles. This lets one build cover different clock rates, and it lets a simulation shorten the settling pause. All pins come from flip-flops, so the device sees clean edges. A reset asserted at any point restarts the whole sequence from the pause.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the pins show a no-operation command (cs_n=0, ras_n=1, cas_n=1, we_n=1), address 0, bank 0, and init_done=0.
- R2: After reset is released, the pins show no-operation for PAUSE_CYC = ceil(PAUSE_NS*1000/CLK_PERIOD_PS) consecutive cycles, counting from the first clock edge with reset low.
- R3: The first command after the pause is a precharge of all banks (cs_n=0, ras_n=0, cas_n=1, we_n=0). It appears in cycle PAUSE_CYC+1 with address bit AP_BIT set, all other address bits clear and bank 0.
- R4: The first auto-refresh follows the precharge by exactly TRP_CYC cycles, and the cycles between them are no-operation.
- R5: Exactly NUM_REFRESH auto-refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1) are issued, each TRC_CYC cycles after the one before, with no-operation between them.
- R6: A mode register write (cs_n, ras_n, cas_n and we_n all 0) follows the last refresh by TRC_CYC cycles. It carries mode_word on the address pins and 0 on the bank pins.
- R7: init_done rises exactly TRSC_CYC cycles after the mode register write, with no-operation in between. From then on it stays high and the pins stay at no-operation until reset.
- R8: sd_cke and every sd_dqm bit are 1 in every cycle, during reset and throughout the sequence.
- R9: A reset asserted partway through the sequence returns the pins to the R1 state and restarts the sequence from the full pause.
- R10: TRP_CYC and TRC_CYC are the nanosecond figures divided by the clock period and rounded up (never less than 1). With a 10 ns clock, 15 ns gives 2 cycles and 65 ns gives 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| mode_word | input | ADDR_W | Value placed on the address pins during the mode register write |
| sd_cke | output | 1 | Clock enable to the device, held high |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank select |
| sd_addr | output | ADDR_W | Multiplexed address pins |
| sd_dqm | output | DQM_W | Byte masks, held high |
| init_done | output | 1 | High once initialization is complete; stays high until reset |

## Verification
The bench runs with nanosecond figures that do not divide evenly by the clock period. A design that truncated instead of rounding up would issue the precharge and the refreshes a cycle early, before the settling time had been met. Every cycle is compared against an independently built timeline, so an off-by-one count, a missing or extra refresh, or a command held for two cycles shows up at the cycle where it happens. A reset in the middle of the refresh train checks that no stale refresh count or timer value carries over, which would otherwise shorten the next pause or skip refreshes. Two different mode words catch an address mux that latches a constant or places the precharge bit into the mode write.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Command pin group, ordered chip-select, row, column, write.
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

    localparam cmd_t CMD_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_t CMD_PRE_ALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam cmd_t CMD_REFRESH = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam cmd_t CMD_MODE    = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    // Which command fires when the wait timer next expires.
    typedef enum logic [1:0] {
        PH_PRE   = 2'd0,
        PH_REF   = 2'd1,
        PH_MODE  = 2'd2,
        PH_READY = 2'd3
    } phase_t;

    // Round a nanosecond figure up to whole clock periods, at least one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sit_countdown.sv
module sit_countdown #(
    parameter int unsigned WIDTH     = 16,
    parameter int unsigned RESET_VAL = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             zero
);

    logic [WIDTH-1:0] value_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= WIDTH'(RESET_VAL);
        end else if (load) begin
            value_q <= load_val;
        end else if (value_q != '0) begin
            value_q <= value_q - WIDTH'(1);
        end
    end

    assign zero = (value_q == '0);

    // R2: after reset the counter starts loaded, so it cannot report expiry at once.
    a_r2_no_early_expiry: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && RESET_VAL > 1) |-> !zero);

endmodule

// File: rtl/sit_step_fsm.sv
module sit_step_fsm
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned AP_BIT      = 10,
    parameter int unsigned TIMER_W     = 16,
    parameter int unsigned NUM_REFRESH = 8,
    parameter int unsigned TRP_CYC     = 2,
    parameter int unsigned TRC_CYC     = 7,
    parameter int unsigned TRSC_CYC    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              timer_zero,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              timer_load,
    output logic [TIMER_W-1:0] timer_val,
    output cmd_t              cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    localparam int unsigned REF_W = (NUM_REFRESH > 1) ? $clog2(NUM_REFRESH) : 1;
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(NUM_REFRESH - 1);

    phase_t           phase_q, phase_d;
    logic [REF_W-1:0] ref_cnt_q, ref_cnt_d;
    logic             fire;

    assign fire = timer_zero && (phase_q != PH_READY);

    always_comb begin
        phase_d    = phase_q;
        ref_cnt_d  = ref_cnt_q;
        timer_load = 1'b0;
        timer_val  = '0;
        cmd        = CMD_NOP;
        addr       = '0;
        if (fire) begin
            timer_load = 1'b1;
            unique case (phase_q)
                PH_PRE: begin
                    cmd          = CMD_PRE_ALL;
                    addr[AP_BIT] = 1'b1;
                    timer_val    = TIMER_W'(TRP_CYC - 1);
                    phase_d      = PH_REF;
                end
                PH_REF: begin
                    cmd       = CMD_REFRESH;
                    timer_val = TIMER_W'(TRC_CYC - 1);
                    if (ref_cnt_q == REF_LAST) begin
                        ref_cnt_d = '0;
                        phase_d   = PH_MODE;
                    end else begin
                        ref_cnt_d = ref_cnt_q + REF_W'(1);
                    end
                end
                PH_MODE: begin
                    cmd       = CMD_MODE;
                    addr      = mode_word;
                    timer_val = TIMER_W'(TRSC_CYC - 1);
                    phase_d   = PH_READY;
                end
                default: begin
                    timer_load = 1'b0;
                end
            endcase
        end
    end

    assign done = (phase_q == PH_READY) && timer_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_PRE;
            ref_cnt_q <= '0;
        end else begin
            phase_q   <= phase_d;
            ref_cnt_q <= ref_cnt_d;
        end
    end

    // R6: the mode write is only reached after the final refresh of the train.
    a_r6_mode_after_train: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_MODE) |-> (ref_cnt_q == '0 && $past(phase_q) != PH_PRE));

    // R7: once ready, the sequencer never issues another command.
    a_r7_ready_is_final: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_READY) |=> (phase_q == PH_READY));

endmodule

// File: rtl/sit_pin_reg.sv
module sit_pin_reg
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned DQM_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              done_in,
    output cmd_t              cmd_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BANK_W-1:0] ba_q,
    output logic              cke_q,
    output logic [DQM_W-1:0]  dqm_q,
    output logic              done_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_NOP;
            addr_q <= '0;
            done_q <= 1'b0;
        end else begin
            cmd_q  <= cmd_in;
            addr_q <= addr_in;
            done_q <= done_in;
        end
        // Bank is zero for every command of this sequence; clock enable and masks stay high.
        ba_q  <= '0;
        cke_q <= 1'b1;
        dqm_q <= '1;
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned PAUSE_NS      = 200000,
    parameter int unsigned TRP_NS        = 20,
    parameter int unsigned TRC_NS        = 65,
    parameter int unsigned TRSC_CYC      = 2,
    parameter int unsigned NUM_REFRESH   = 8,
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned BANK_W        = 2,
    parameter int unsigned DQM_W         = 2,
    parameter int unsigned AP_BIT        = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              init_done
);

    localparam int unsigned PAUSE_CYC = ns_to_cycles(PAUSE_NS, CLK_PERIOD_PS);
    localparam int unsigned TRP_CYC   = ns_to_cycles(TRP_NS, CLK_PERIOD_PS);
    localparam int unsigned TRC_CYC   = ns_to_cycles(TRC_NS, CLK_PERIOD_PS);
    localparam int unsigned MAX_CYC   = max3(PAUSE_CYC, max3(TRP_CYC, TRC_CYC, TRSC_CYC), 1);
    localparam int unsigned TIMER_W   = $clog2(MAX_CYC + 1);
    localparam int unsigned GAP_MAX   = max3(TRP_CYC, TRC_CYC, TRSC_CYC);
    localparam int unsigned SEEN_W    = $clog2(NUM_REFRESH + 1) + 1;

    logic               timer_load;
    logic [TIMER_W-1:0] timer_val;
    logic               timer_zero;
    cmd_t               next_cmd;
    logic [ADDR_W-1:0]  next_addr;
    logic               next_done;
    cmd_t               pin_cmd;

    sit_countdown #(
        .WIDTH     (TIMER_W),
        .RESET_VAL (PAUSE_CYC)
    ) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .zero     (timer_zero)
    );

    sit_step_fsm #(
        .ADDR_W      (ADDR_W),
        .AP_BIT      (AP_BIT),
        .TIMER_W     (TIMER_W),
        .NUM_REFRESH (NUM_REFRESH),
        .TRP_CYC     (TRP_CYC),
        .TRC_CYC     (TRC_CYC),
        .TRSC_CYC    (TRSC_CYC)
    ) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .timer_zero (timer_zero),
        .mode_word  (mode_word),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .cmd        (next_cmd),
        .addr       (next_addr),
        .done       (next_done)
    );

    sit_pin_reg #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .DQM_W  (DQM_W)
    ) i_pins (
        .clk     (clk),
        .rst     (rst),
        .cmd_in  (next_cmd),
        .addr_in (next_addr),
        .done_in (next_done),
        .cmd_q   (pin_cmd),
        .addr_q  (sd_addr),
        .ba_q    (sd_ba),
        .cke_q   (sd_cke),
        .dqm_q   (sd_dqm),
        .done_q  (init_done)
    );

    assign sd_cs_n  = pin_cmd.cs_n;
    assign sd_ras_n = pin_cmd.ras_n;
    assign sd_cas_n = pin_cmd.cas_n;
    assign sd_we_n  = pin_cmd.we_n;

    // Pin-level observers for the ordering and gap properties below.
    logic               pin_is_nop, pin_is_pre, pin_is_ref, pin_is_mode;
    logic [TIMER_W-1:0] since_cmd_q;
    logic               last_pre_q;
    logic [SEEN_W-1:0]  ref_seen_q;

    assign pin_is_nop  = (pin_cmd == CMD_NOP);
    assign pin_is_pre  = (pin_cmd == CMD_PRE_ALL);
    assign pin_is_ref  = (pin_cmd == CMD_REFRESH);
    assign pin_is_mode = (pin_cmd == CMD_MODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_cmd_q <= '0;
            last_pre_q  <= 1'b0;
            ref_seen_q  <= '0;
        end else begin
            if (!pin_is_nop) begin
                since_cmd_q <= TIMER_W'(1);
                last_pre_q  <= pin_is_pre;
            end else if (since_cmd_q < TIMER_W'(GAP_MAX)) begin
                since_cmd_q <= since_cmd_q + TIMER_W'(1);
            end
            if (pin_is_ref) begin
                ref_seen_q <= ref_seen_q + SEEN_W'(1);
            end
        end
    end

    // R3: the precharge is the first command and closes all banks.
    a_r3_precharge_all: assert property (@(posedge clk) disable iff (rst)
        pin_is_pre |-> (sd_addr[AP_BIT] && ref_seen_q == '0 && !init_done));

    // R4 / R5: each refresh honours the gap after the previous command.
    a_r5_refresh_gap: assert property (@(posedge clk) disable iff (rst)
        pin_is_ref |-> (since_cmd_q >= (last_pre_q ? TIMER_W'(TRP_CYC) : TIMER_W'(TRC_CYC))));

    // R6: the mode write sees the full refresh train behind it.
    a_r6_mode_after_refreshes: assert property (@(posedge clk) disable iff (rst)
        pin_is_mode |-> (ref_seen_q == SEEN_W'(NUM_REFRESH) && since_cmd_q >= TIMER_W'(TRC_CYC)));

    // R7: completion is sticky and quiet.
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (pin_is_nop && since_cmd_q >= TIMER_W'(TRSC_CYC)));

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

    localparam int ADDR_W = 12;
    localparam int BANK_W = 2;
    localparam int DQM_W  = 2;

    // Expected counts, worked out by hand from the requirements (R10):
    // 495 ns / 10 ns -> 50, 15 ns -> 2, 65 ns -> 7.
    localparam int P_CYC    = 50;
    localparam int TRP_C    = 2;
    localparam int TRC_C    = 7;
    localparam int TRSC_C   = 2;
    localparam int NREF     = 8;
    localparam int MODE_AT  = P_CYC + 1 + TRP_C + NREF * TRC_C;

    localparam logic [3:0] E_NOP = 4'b0111;
    localparam logic [3:0] E_PRE = 4'b0010;
    localparam logic [3:0] E_REF = 4'b0001;
    localparam logic [3:0] E_MRS = 4'b0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] mode_word = '0;
    logic              sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
    logic [BANK_W-1:0] sd_ba;
    logic [ADDR_W-1:0] sd_addr;
    logic [DQM_W-1:0]  sd_dqm;

    always #5 clk = ~clk;

    sdram_init_seq #(
        .CLK_PERIOD_PS (10000),
        .PAUSE_NS      (495),
        .TRP_NS        (15),
        .TRC_NS        (65),
        .TRSC_CYC      (2),
        .NUM_REFRESH   (8),
        .ADDR_W        (ADDR_W),
        .BANK_W        (BANK_W),
        .DQM_W         (DQM_W),
        .AP_BIT        (10)
    ) i_sdram_init_seq (
        .clk       (clk),
        .rst       (rst),
        .mode_word (mode_word),
        .sd_cke    (sd_cke),
        .sd_cs_n   (sd_cs_n),
        .sd_ras_n  (sd_ras_n),
        .sd_cas_n  (sd_cas_n),
        .sd_we_n   (sd_we_n),
        .sd_ba     (sd_ba),
        .sd_addr   (sd_addr),
        .sd_dqm    (sd_dqm),
        .init_done (init_done)
    );

    typedef struct {
        logic [3:0]        cmd;
        logic [ADDR_W-1:0] addr;
        logic              done;
        string             tag;
        int                cyc;
    } exp_t;

    exp_t expq[$];
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;

    function automatic logic [3:0] pin_cmd();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    // Driver: build the expected per-cycle timeline after reset release.
    task automatic push_timeline(input logic [ADDR_W-1:0] mw, input int ncyc);
        for (int k = 1; k <= ncyc; k++) begin
            exp_t e;
            e.cmd  = E_NOP;
            e.addr = '0;
            e.done = 1'b0;
            e.cyc  = k;
            if (k <= P_CYC) begin
                e.tag = "R2";
            end else if (k == P_CYC + 1) begin
                e.cmd  = E_PRE;
                e.addr = 12'h400;
                e.tag  = "R3 R10";
            end else if (k < P_CYC + 1 + TRP_C) begin
                e.tag = "R4";
            end else if (k < MODE_AT) begin
                e.tag = "R5 R10";
                if (((k - (P_CYC + 1 + TRP_C)) % TRC_C) == 0) e.cmd = E_REF;
            end else if (k == MODE_AT) begin
                e.cmd  = E_MRS;
                e.addr = mw;
                e.tag  = "R6";
            end else begin
                e.tag  = "R7";
                e.done = (k >= MODE_AT + TRSC_C);
            end
            expq.push_back(e);
        end
    endtask

    task automatic check_reset_state(input string tag);
        checks++;
        if (pin_cmd() !== E_NOP || sd_addr !== '0 || sd_ba !== '0 || init_done !== 1'b0) begin
            errors++;
            $display("FAIL %s reset state: got cmd=%b addr=%h ba=%h done=%b, expected cmd=%b addr=000 ba=0 done=0",
                     tag, pin_cmd(), sd_addr, sd_ba, init_done, E_NOP);
        end
        checks++;
        if (sd_cke !== 1'b1 || sd_dqm !== '1) begin
            errors++;
            $display("FAIL R8 in reset: got cke=%b dqm=%b, expected cke=1 dqm=11", sd_cke, sd_dqm);
        end
    endtask

    // Monitor: compare pins with the next expected item, mid-cycle.
    always @(negedge clk) begin
        if (mon_on && expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            checks++;
            if (pin_cmd() !== e.cmd || sd_addr !== e.addr || sd_ba !== '0 || init_done !== e.done) begin
                errors++;
                $display("FAIL %s cycle %0d: got cmd=%b addr=%h ba=%h done=%b, expected cmd=%b addr=%h ba=0 done=%b",
                         e.tag, e.cyc, pin_cmd(), sd_addr, sd_ba, init_done, e.cmd, e.addr, e.done);
            end
            checks++;
            if (sd_cke !== 1'b1 || sd_dqm !== '1) begin
                errors++;
                $display("FAIL R8 cycle %0d: got cke=%b dqm=%b, expected cke=1 dqm=11",
                         e.cyc, sd_cke, sd_dqm);
            end
        end
    end

    task automatic run_from_reset(input logic [ADDR_W-1:0] mw, input int ncyc);
        mode_word = mw;
        push_timeline(mw, ncyc);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        mon_on = 1'b1;
        wait (expq.size() == 0);
        @(posedge clk);
        mon_on = 1'b0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset_state("R1");

        // Full sequence with one mode word, then linger to see done stay high (R7).
        run_from_reset(12'h032, MODE_AT + TRSC_C + 20);

        // Reset from the ready state and from mid-refresh (R9).
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_state("R9");
        run_from_reset(12'h2A5, P_CYC + 1 + TRP_C + 3 * TRC_C + 2);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_reset_state("R9");

        // Restart runs the full pause and a fresh refresh train with a new mode word.
        run_from_reset(12'h9C7, MODE_AT + TRSC_C + 10);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule